// File: doc/BRIEF.md
# Fixed-Point Chaotic Oscillator with Seven-Stage Runge-Kutta Stepping

This block integrates a three-variable quadratic chaotic flow. It advances the state with a seven-stage embedded Runge-Kutta step of fifth order. All values are signed 32-bit words with 16 fractional bits. A one-cycle start pulse loads a fixed initial state. From then on the block steps continuously, and it raises a one-cycle strobe each time a fresh (x, y, z) triple is on its outputs. A downstream quantiser or bit extractor would take these triples as its entropy source.

The flow is dx/dt = y, dy/dt = -x + y·z, dz/dt = z + a·x² - y² - b, with a = 8.888 and b = 4. The step size is fixed at 2^-7, so scaling by the step is an arithmetic right shift by 7. One multiplier is shared across all of the work. A small sequencer builds every stage input point and then evaluates the vector field there. The last stage of each step is evaluated at the new state, and its result is kept as the first stage of the next step. Every step after the first therefore needs six field evaluations.

Top module: `dp_chaos_osc`

## Requirements
- R1: When start is sampled high, the outputs on the following cycle are x = 0, y = 255590 (3.9) and z = 45875 (0.7).
- R2: A product of two words is the full 64-bit signed product with bits [47:16] kept, which truncates toward minus infinity. All sums wrap modulo 2^32.
- R3: Each constant is 65536 times its rational value, rounded to the nearest integer with ties away from zero. This gives a = 582484 and b = 262144.
- R4: The input point of stage s (s = 2..7) for each variable is the state plus (the sum of the products coef(s,j)·k_j, accumulated in order j = 1..s-1) arithmetically shifted right by 7. The stage-7 row is the fifth-order weight set, and its k2 weight is 0.
- R5: At a point (px, py, pz) the derivative is dx = py, dy = mul(py,pz) - px and dz = pz + mul(a, mul(px,px)) - mul(py,py) - b.
- R6: The first valid comes 91 cycles after the start edge. Each later valid follows the previous one after 87 cycles, because the stage-7 derivative is reused as k1 of the next step.
- R7: valid is high for exactly one cycle. The outputs change only on the cycle after start is sampled or on a cycle where valid is high.
- R8: Each new state equals the stage-7 input point. After N steps the outputs match a bit-exact integer model of R2 to R5.
- R9: A start pulse during a step abandons that step, reloads the initial state and restarts the timing of R6.
- R10: After reset the outputs are 0 and valid stays low until start is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the initial state and begin stepping |
| valid | output | 1 | One-cycle strobe: a new state triple is on the outputs |
| x_out | output | 32 | State x, signed Q16.16 |
| y_out | output | 32 | State y, signed Q16.16 |
| z_out | output | 32 | State z, signed Q16.16 |

## Verification
The timing assertions assume that start is a single-cycle pulse and that it never coincides with the cycle in which valid is set. A start held for several cycles would keep reloading the state and push back the 91-cycle count. The bench drives start high for exactly one cycle at a negative edge. It issues the mid-run restart a fixed 40 cycles after a valid, well away from the next one. The trajectory starts at the fixed initial state, so every intermediate value stays far inside the Q16.16 range. The wrap rules of R2 are therefore checked only through exact agreement with the model.

// File: rtl/dp_chaos_osc.sv
module dp_chaos_osc #(
  parameter int W     = 32,
  parameter int FRAC  = 16,
  parameter int HSH   = 7,
  parameter int NSTG  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                valid,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out
);
  localparam int SW = $clog2(NSTG);

  function automatic logic signed [W-1:0] q(input longint n, input longint d);
    longint an, ad, r;
    an = (n < 0) ? -n : n;
    ad = (d < 0) ? -d : d;
    r  = (an * (longint'(1) << FRAC) + ad / 2) / ad;
    return ((n < 0) != (d < 0)) ? W'(-r) : W'(r);
  endfunction

  localparam logic signed [W-1:0] PA  = q(8888, 1000);
  localparam logic signed [W-1:0] PB  = q(4, 1);
  localparam logic signed [W-1:0] Y0  = q(39, 10);
  localparam logic signed [W-1:0] Z0  = q(7, 10);
  localparam logic signed [W-1:0] C10 = q(1, 5);
  localparam logic signed [W-1:0] C20 = q(3, 40);
  localparam logic signed [W-1:0] C21 = q(9, 40);
  localparam logic signed [W-1:0] C30 = q(44, 45);
  localparam logic signed [W-1:0] C31 = q(-56, 15);
  localparam logic signed [W-1:0] C32 = q(32, 9);
  localparam logic signed [W-1:0] C40 = q(19372, 6561);
  localparam logic signed [W-1:0] C41 = q(-25360, 2187);
  localparam logic signed [W-1:0] C42 = q(64448, 6561);
  localparam logic signed [W-1:0] C43 = q(-212, 729);
  localparam logic signed [W-1:0] C50 = q(9017, 3168);
  localparam logic signed [W-1:0] C51 = q(-355, 33);
  localparam logic signed [W-1:0] C52 = q(46732, 5247);
  localparam logic signed [W-1:0] C53 = q(49, 176);
  localparam logic signed [W-1:0] C54 = q(-5103, 18656);
  localparam logic signed [W-1:0] C60 = q(35, 384);
  localparam logic signed [W-1:0] C62 = q(500, 1113);
  localparam logic signed [W-1:0] C63 = q(125, 192);
  localparam logic signed [W-1:0] C64 = q(-2187, 6784);
  localparam logic signed [W-1:0] C65 = q(11, 84);

  typedef enum logic [1:0] {IDLE, COMB, DERIV} ph_t;

  ph_t                ph;
  logic [SW-1:0]      stg, jj;
  logic [1:0]         vi, dph;
  logic signed [W-1:0] st [3];
  logic signed [W-1:0] pt [3];
  logic signed [W-1:0] kr [NSTG][3];
  logic signed [W-1:0] acc, xx, ax, yz;
  logic signed [W-1:0] coef, mul_a, mul_b, p, acc_nx, kdy, kdz;
  logic signed [2*W-1:0] prod;

  always_comb begin
    case ({stg, jj})
      6'o10: coef = C10;
      6'o20: coef = C20; 6'o21: coef = C21;
      6'o30: coef = C30; 6'o31: coef = C31; 6'o32: coef = C32;
      6'o40: coef = C40; 6'o41: coef = C41; 6'o42: coef = C42; 6'o43: coef = C43;
      6'o50: coef = C50; 6'o51: coef = C51; 6'o52: coef = C52; 6'o53: coef = C53;
      6'o54: coef = C54;
      6'o60: coef = C60; 6'o62: coef = C62; 6'o63: coef = C63; 6'o64: coef = C64;
      6'o65: coef = C65;
      default: coef = '0;
    endcase
  end

  always_comb begin
    mul_a = coef;
    mul_b = kr[jj][vi];
    if (ph == DERIV) begin
      case (dph)
        2'd0: begin mul_a = pt[0]; mul_b = pt[0]; end
        2'd1: begin mul_a = PA;    mul_b = xx;    end
        2'd2: begin mul_a = pt[1]; mul_b = pt[2]; end
        default: begin mul_a = pt[1]; mul_b = pt[1]; end
      endcase
    end
  end

  assign prod   = mul_a * mul_b;
  assign p      = prod[2*W-FRAC-1:FRAC];
  assign acc_nx = ((jj == '0) ? '0 : acc) + p;
  assign kdy    = yz - pt[0];
  assign kdz    = pt[2] + ax - p - PB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; stg <= '0; jj <= '0; vi <= '0; dph <= '0; valid <= 1'b0;
      acc <= '0; xx <= '0; ax <= '0; yz <= '0;
      for (int v = 0; v < 3; v++) begin
        st[v] <= '0;
        pt[v] <= '0;
        for (int s = 0; s < NSTG; s++) kr[s][v] <= '0;
      end
    end else begin
      valid <= 1'b0;
      if (start) begin
        ph <= DERIV; dph <= '0; stg <= '0; jj <= '0; vi <= '0;
        st[0] <= '0; st[1] <= Y0; st[2] <= Z0;
        pt[0] <= '0; pt[1] <= Y0; pt[2] <= Z0;
      end else begin
        case (ph)
          COMB: begin
            acc <= acc_nx;
            if (jj == stg - SW'(1)) begin
              pt[vi] <= st[vi] + (acc_nx >>> HSH);
              jj <= '0;
              if (vi == 2'd2) begin
                vi <= '0; ph <= DERIV; dph <= '0;
              end else vi <= vi + 2'd1;
            end else jj <= jj + SW'(1);
          end
          DERIV: begin
            dph <= dph + 2'd1;
            case (dph)
              2'd0: xx <= p;
              2'd1: ax <= p;
              2'd2: yz <= p;
              default: begin
                kr[stg][0] <= pt[1];
                kr[stg][1] <= kdy;
                kr[stg][2] <= kdz;
                ph <= COMB; jj <= '0; vi <= '0;
                if (stg == SW'(NSTG - 1)) begin
                  kr[0][0] <= pt[1]; kr[0][1] <= kdy; kr[0][2] <= kdz;
                  for (int v = 0; v < 3; v++) st[v] <= pt[v];
                  valid <= 1'b1;
                  stg <= SW'(1);
                end else stg <= stg + SW'(1);
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign x_out = st[0];
  assign y_out = st[1];
  assign z_out = st[2];

  logic [7:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cyc <= '0;
    else if (start) cyc <= '0;
    else if (valid) cyc <= 8'd1;
    else            cyc <= cyc + 8'd1;
  end

  assert_init_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (x_out == '0 && y_out == Y0 && z_out == Z0));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(x_out) || !$stable(y_out) || !$stable(z_out)) |-> (valid || $past(start)));

  assert_fsal_reuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (kr[0][0] == y_out));

  assert_step_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cyc == 8'd91 || cyc == 8'd87));
endmodule

// File: tb/dp_chaos_osc_bench.sv
`timescale 1ns/1ps
module dp_chaos_osc_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic valid;
  logic signed [31:0] x_out, y_out, z_out;

  dp_chaos_osc u_dp_chaos_osc (.clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
                               .x_out(x_out), .y_out(y_out), .z_out(z_out));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int ms [3];
  int mk [7][3];

  function automatic int qc(longint n, longint d);
    longint an, ad, r;
    an = (n < 0) ? -n : n;
    ad = (d < 0) ? -d : d;
    r = (an * 65536 + ad / 2) / ad;
    return ((n < 0) != (d < 0)) ? int'(-r) : int'(r);
  endfunction

  function automatic int mq(int a, int b);
    longint pr;
    pr = longint'(a) * longint'(b);
    return int'(pr >>> 16);
  endfunction

  function automatic int cf(int s, int j);
    case (s * 10 + j)
      10: return qc(1, 5);
      20: return qc(3, 40);       21: return qc(9, 40);
      30: return qc(44, 45);      31: return qc(-56, 15);     32: return qc(32, 9);
      40: return qc(19372, 6561); 41: return qc(-25360, 2187);
      42: return qc(64448, 6561); 43: return qc(-212, 729);
      50: return qc(9017, 3168);  51: return qc(-355, 33);    52: return qc(46732, 5247);
      53: return qc(49, 176);     54: return qc(-5103, 18656);
      60: return qc(35, 384);     62: return qc(500, 1113);   63: return qc(125, 192);
      64: return qc(-2187, 6784); 65: return qc(11, 84);
      default: return 0;
    endcase
  endfunction

  task automatic field(input int px, input int py, input int pz, input int s);
    mk[s][0] = py;
    mk[s][1] = mq(py, pz) - px;
    mk[s][2] = pz + mq(qc(8888, 1000), mq(px, px)) - mq(py, py) - qc(4, 1);
  endtask

  task automatic model_reset();
    ms[0] = 0; ms[1] = qc(39, 10); ms[2] = qc(7, 10);
    field(ms[0], ms[1], ms[2], 0);
  endtask

  task automatic model_step();
    int pnt [3];
    for (int s = 1; s < 7; s++) begin
      for (int v = 0; v < 3; v++) begin
        int acc = 0;
        for (int j = 0; j < s; j++) acc = acc + mq(cf(s, j), mk[j][v]);
        pnt[v] = ms[v] + (acc >>> 7);
      end
      field(pnt[0], pnt[1], pnt[2], s);
    end
    for (int v = 0; v < 3; v++) begin
      ms[v] = pnt[v];
      mk[0][v] = mk[6][v];
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(output int n, output bit held);
    int sx, sy, sz;
    sx = x_out; sy = y_out; sz = z_out;
    n = 0; held = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!valid && (x_out != sx || y_out != sy || z_out != sz)) held = 1'b0;
    end while (!valid && n < 300);
    if (n >= 300) chk("R6 watchdog on valid", n, 0);
  endtask

  task automatic t_reset();
    bit quiet = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (valid || x_out != 0 || y_out != 0 || z_out != 0) quiet = 1'b0;
    end
    chk("R10 idle after reset", int'(quiet), 1);
  endtask

  task automatic t_run(input int nstep);
    int n; bit held;
    model_reset();
    pulse_start();
    chk("R1 x init", x_out, 0);
    chk("R1 y init", y_out, 255590);
    chk("R1 z init", z_out, 45875);
    wait_valid(n, held);
    chk("R6 first latency", n, 91);
    model_step();
    chk("R4 step1 x", x_out, ms[0]);
    chk("R2 R5 step1 y", y_out, ms[1]);
    chk("R3 R5 step1 z", z_out, ms[2]);
    for (int s = 2; s <= nstep; s++) begin
      @(negedge clk);
      chk("R7 valid width", int'(valid), 0);
      wait_valid(n, held);
      chk("R6 step period", n + 1, 87);
      chk("R7 outputs held", int'(held), 1);
      model_step();
      chk("R8 x", x_out, ms[0]);
      chk("R8 y", y_out, ms[1]);
      chk("R8 z", z_out, ms[2]);
    end
  endtask

  task automatic t_restart();
    int n; bit held;
    for (int i = 0; i < 40; i++) @(negedge clk);
    model_reset();
    pulse_start();
    chk("R9 x reload", x_out, 0);
    chk("R9 y reload", y_out, 255590);
    chk("R9 z reload", z_out, 45875);
    wait_valid(n, held);
    chk("R9 restart latency", n, 91);
    model_step();
    chk("R9 x after restart", x_out, ms[0]);
    chk("R9 y after restart", y_out, ms[1]);
    chk("R9 z after restart", z_out, ms[2]);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run(14);
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule